// File: doc/BRIEF.md
# Address Generation Unit with Address Writeback

This block forms the memory address for a load/store pipeline stage. It adds a base register value, an index register value scaled by four, and a sign-extended immediate offset, with all arithmetic wrapping modulo 2^32. Alongside the memory address, it can return the computed address to a register through a second, dedicated write port. This write port gives pre-modify addressing, where the new address is both used and saved. It also gives post-modify addressing, where the old base is used for the access and the register is then advanced to the new address.

When the scaled base sum is known to be aligned, the offset can be merged with a bitwise OR instead of an addition. The unit checks that the alignment actually holds, and it falls back to the adder when it does not. A build-time policy can limit address writeback to instructions that have no normal result, such as stores. Under that policy, a load that asks for writeback is flagged and its writeback is dropped.

There is one registered stage. Results appear on the cycle after the operation is presented with `in_valid` high.

Top module: `agu_wb`

## Requirements
- R1: In plain mode (`in_mode`=0), `mem_addr` = base + (index << 2) + sign-extended offset, taken modulo 2^32, and `wb_valid` stays 0.
- R2: In pre-modify mode (`in_mode`=1), `mem_addr` and `wb_data` both equal the computed address, `wb_valid`=1, and `wb_tag` equals the tag that was presented.
- R3: In post-modify mode (`in_mode`=2), `mem_addr` equals the unmodified base and `wb_data` equals the computed address, both produced in the same cycle, with `wb_valid`=1.
- R4: With the restricted policy on (`RESTRICT_WB`=1, the default), a load (`in_is_load`=1) in mode 1 or 2 raises `illegal` and leaves `wb_valid` at 0. Its `mem_addr` still follows the mode. A store in the same modes writes back normally.
- R5: With `in_or_comb`=1, the offset non-negative and bits [OFF_W-1:0] of base + (index << 2) all zero, the offset is merged by bitwise OR. The resulting address equals the sum, and `illegal` stays 0.
- R6: With `in_or_comb`=1 and either a negative offset or a nonzero bit in [OFF_W-1:0] of the scaled sum, `illegal`=1 and the adder result is used for the address.
- R7: Mode value 3 is reserved. It raises `illegal`, behaves as plain mode for the address, and produces no writeback.
- R8: `out_valid` equals `in_valid` delayed by one clock. `wb_valid` and `illegal` are only ever 1 while `out_valid` is 1.
- R9: After synchronous reset, `out_valid`, `wb_valid` and `illegal` are 0, and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value, scaled by 4 |
| in_offset | input | 12 | Signed immediate offset |
| in_mode | input | 2 | 0 plain, 1 pre-modify, 2 post-modify, 3 reserved |
| in_or_comb | input | 1 | Request OR merge of the offset |
| in_is_load | input | 1 | 1 load (has a normal result), 0 store |
| in_wb_tag | input | 5 | Destination register for address writeback |
| out_valid | output | 1 | Registered result valid |
| mem_addr | output | 32 | Address sent to memory |
| wb_valid | output | 1 | Address writeback request |
| wb_tag | output | 5 | Address writeback destination |
| wb_data | output | 32 | Address writeback value |
| illegal | output | 1 | Illegal combination detected |

## Verification
The hardest case to reach is a legal OR merge. It needs the low twelve bits of base plus four times index to be exactly zero, and a uniformly random base and index almost never produce that. The random stimulus therefore masks the low bits of the base and index on a share of the operations, so that aligned sums come up often. Each such operation is paired with an offset that is either non-negative or negative, which also exercises R6 in the aligned case. Loads and stores are mixed across all four mode codes, so that the policy check meets both pre-modify and post-modify requests.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_PLAIN = 2'd0,
    AM_PRE   = 2'd1,
    AM_POST  = 2'd2,
    AM_RSVD  = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_scale_sum.sv
module agu_scale_sum #(
  parameter int ADDR_W    = 32,
  parameter int IDX_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  output logic [ADDR_W-1:0] sum
);
  logic [ADDR_W-1:0] scaled;
  always_comb begin
    scaled = index << IDX_SHIFT;
    sum    = base + scaled;
  end
endmodule

// File: rtl/agu_offset_merge.sv
module agu_offset_merge #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter bit OR_EN  = 1'b1
) (
  input  logic [ADDR_W-1:0] sum,
  input  logic [OFF_W-1:0]  offset,
  input  logic              or_req,
  output logic [ADDR_W-1:0] ea,
  output logic              or_bad
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_sx;
  logic [ADDR_W-1:0] add_res;
  assign off_sx  = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign add_res = sum + off_sx;

  generate
    if (OR_EN) begin : g_or
      logic aligned;
      logic or_ok;
      assign aligned = (sum[OFF_W-1:0] == '0);
      assign or_ok   = aligned && !offset[OFF_W-1];
      always_comb begin
        if (or_req && or_ok) ea = {sum[ADDR_W-1:OFF_W], sum[OFF_W-1:0] | offset};
        else                 ea = add_res;
        or_bad = or_req && !or_ok;
      end
    end else begin : g_add
      always_comb begin
        ea     = add_res;
        or_bad = or_req;
      end
    end
  endgenerate
endmodule

// File: rtl/agu_wb_policy.sv
module agu_wb_policy
  import agu_pkg::*;
#(
  parameter bit RESTRICT_WB = 1'b1
) (
  input  logic [1:0] mode,
  input  logic       is_load,
  output logic       use_base,
  output logic       wb_req,
  output logic       mode_bad
);
  agu_mode_e m;
  logic      wants_wb;
  logic      blocked;
  always_comb begin
    m        = agu_mode_e'(mode);
    wants_wb = (m == AM_PRE) || (m == AM_POST);
    blocked  = RESTRICT_WB && is_load && wants_wb;
    use_base = (m == AM_POST);
    wb_req   = wants_wb && !blocked;
    mode_bad = blocked || (m == AM_RSVD);
  end
endmodule

// File: rtl/agu_wb.sv
module agu_wb #(
  parameter int ADDR_W      = 32,
  parameter int IDX_SHIFT   = 2,
  parameter int OFF_W       = 12,
  parameter int TAG_W       = 5,
  parameter bit OR_EN       = 1'b1,
  parameter bit RESTRICT_WB = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_index,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic [1:0]        in_mode,
  input  logic              in_or_comb,
  input  logic              in_is_load,
  input  logic [TAG_W-1:0]  in_wb_tag,
  output logic              out_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [ADDR_W-1:0] wb_data,
  output logic              illegal
);
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] ea;
  logic              or_bad;
  logic              use_base;
  logic              wb_req;
  logic              mode_bad;

  agu_scale_sum #(.ADDR_W(ADDR_W), .IDX_SHIFT(IDX_SHIFT)) u_sum (
    .base(in_base), .index(in_index), .sum(sum)
  );

  agu_offset_merge #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .OR_EN(OR_EN)) u_merge (
    .sum(sum), .offset(in_offset), .or_req(in_or_comb), .ea(ea), .or_bad(or_bad)
  );

  agu_wb_policy #(.RESTRICT_WB(RESTRICT_WB)) u_pol (
    .mode(in_mode), .is_load(in_is_load),
    .use_base(use_base), .wb_req(wb_req), .mode_bad(mode_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mem_addr  <= '0;
      wb_valid  <= 1'b0;
      wb_tag    <= '0;
      wb_data   <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wb_valid  <= in_valid && wb_req;
      illegal   <= in_valid && (or_bad || mode_bad);
      if (in_valid) begin
        mem_addr <= use_base ? in_base : ea;
        wb_data  <= ea;
        wb_tag   <= in_wb_tag;
      end
    end
  end
endmodule

// File: rtl/agu_wb_chk.sv
module agu_wb_chk #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int TAG_W       = 5,
  parameter bit RESTRICT_WB = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_base,
  input logic [1:0]        in_mode,
  input logic              in_is_load,
  input logic [TAG_W-1:0]  in_wb_tag,
  input logic              out_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wb_valid,
  input logic [TAG_W-1:0]  wb_tag,
  input logic              illegal
);
  // R8
  p_wb_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> out_valid);
  // R8
  p_valid_delay_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  p_illegal_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> out_valid);
  // R1
  p_plain_no_wb_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd0) |=> !wb_valid);
  // R3
  p_post_uses_base_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd2) |=> (mem_addr == $past(in_base)));
  // R4
  p_load_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    (RESTRICT_WB && in_valid && in_is_load && (in_mode == 2'd1 || in_mode == 2'd2))
      |=> (illegal && !wb_valid));
  // R2
  p_tag_passes_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_is_load && in_mode == 2'd1) |=> (wb_valid && wb_tag == $past(in_wb_tag)));
  // R7
  p_rsvd_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd3) |=> (illegal && !wb_valid));
endmodule

bind agu_wb agu_wb_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .RESTRICT_WB(RESTRICT_WB)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_base(in_base),
  .in_mode(in_mode), .in_is_load(in_is_load), .in_wb_tag(in_wb_tag),
  .out_valid(out_valid), .mem_addr(mem_addr), .wb_valid(wb_valid),
  .wb_tag(wb_tag), .illegal(illegal)
);

// File: tb/agu_wb_tb.sv
module agu_wb_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_base, in_index;
  logic [11:0] in_offset;
  logic [1:0]  in_mode;
  logic        in_or_comb, in_is_load;
  logic [4:0]  in_wb_tag;
  logic        out_valid, wb_valid, illegal;
  logic [31:0] mem_addr, wb_data;
  logic [4:0]  wb_tag;

  int checks = 0;
  int errors = 0;
  int seed_dummy;

  always #2 clk = ~clk;

  agu_wb u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_base(in_base),
    .in_index(in_index), .in_offset(in_offset), .in_mode(in_mode),
    .in_or_comb(in_or_comb), .in_is_load(in_is_load), .in_wb_tag(in_wb_tag),
    .out_valid(out_valid), .mem_addr(mem_addr), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_data(wb_data), .illegal(illegal)
  );

  function automatic logic [31:0] ref_ea(input logic [31:0] b, input logic [31:0] i,
                                         input logic [11:0] o);
    return b + (i * 32'd4) + {{20{o[11]}}, o};
  endfunction

  function automatic logic ref_illegal(input logic [31:0] b, input logic [31:0] i,
                                       input logic [11:0] o, input logic [1:0] m,
                                       input logic orq, input logic ld);
    logic [31:0] s;
    logic r;
    s = b + (i * 32'd4);
    r = 1'b0;
    if (orq && (o[11] || s[11:0] != 12'd0)) r = 1'b1;
    if (m == 2'd3) r = 1'b1;
    if (ld && (m == 2'd1 || m == 2'd2)) r = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] b, input logic [31:0] i, input logic [11:0] o,
                        input logic [1:0] m, input logic orq, input logic ld,
                        input logic [4:0] t, input string req);
    logic [31:0] ea;
    logic        ex_wb;
    logic        ex_ill;
    @(negedge clk);
    in_valid = 1'b1; in_base = b; in_index = i; in_offset = o;
    in_mode = m; in_or_comb = orq; in_is_load = ld; in_wb_tag = t;
    ea     = ref_ea(b, i, o);
    ex_ill = ref_illegal(b, i, o, m, orq, ld);
    ex_wb  = (m == 2'd1 || m == 2'd2) && !ld;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
    chk(req, "mem_addr", mem_addr, (m == 2'd2) ? b : ea);
    chk(req, "wb_valid", {31'd0, wb_valid}, {31'd0, ex_wb});
    chk(req, "illegal", {31'd0, illegal}, {31'd0, ex_ill});
    if (ex_wb) begin
      chk(req, "wb_data", wb_data, ea);
      chk(req, "wb_tag", {27'd0, wb_tag}, {27'd0, t});
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd1234);
    rst = 1'b1; in_valid = 1'b0; in_base = '0; in_index = '0; in_offset = '0;
    in_mode = '0; in_or_comb = 1'b0; in_is_load = 1'b0; in_wb_tag = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9", "wb_valid", {31'd0, wb_valid}, 32'd0);
    chk("R9", "illegal", {31'd0, illegal}, 32'd0);
    chk("R9", "mem_addr", mem_addr, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 plain with negative offset and wrap
    run_op(32'h0000_0010, 32'h0000_0001, 12'hFF0, 2'd0, 1'b0, 1'b1, 5'd3, "R1");
    run_op(32'hFFFF_FFF0, 32'h0000_0008, 12'h004, 2'd0, 1'b0, 1'b0, 5'd3, "R1");
    // R2 pre-modify store
    run_op(32'h1000_0000, 32'h0000_0010, 12'h020, 2'd1, 1'b0, 1'b0, 5'd9, "R2");
    // R3 post-modify store
    run_op(32'h2000_0100, 32'h0000_0003, 12'h7FF, 2'd2, 1'b0, 1'b0, 5'd17, "R3");
    // R4 load requesting writeback, both modes
    run_op(32'h3000_0000, 32'h0000_0004, 12'h008, 2'd1, 1'b0, 1'b1, 5'd5, "R4");
    run_op(32'h3000_0040, 32'h0000_0004, 12'h008, 2'd2, 1'b0, 1'b1, 5'd5, "R4");
    // R5 legal OR merge
    run_op(32'h4000_0000, 32'h0000_0400, 12'h7FC, 2'd1, 1'b1, 1'b0, 5'd31, "R5");
    // R6 misaligned sum, and negative offset on aligned sum
    run_op(32'h4000_0004, 32'h0000_0000, 12'h00C, 2'd0, 1'b1, 1'b0, 5'd1, "R6");
    run_op(32'h4000_0000, 32'h0000_0000, 12'hFFC, 2'd0, 1'b1, 1'b0, 5'd1, "R6");
    // R7 reserved mode
    run_op(32'h5000_0000, 32'h0000_0002, 12'h010, 2'd3, 1'b0, 1'b0, 5'd2, "R7");

    // R8 idle cycle: out_valid drops, no writeback or flag
    @(negedge clk);
    in_valid = 1'b0; in_mode = 2'd1; in_is_load = 1'b0;
    @(posedge clk);
    #1;
    chk("R8", "out_valid idle", {31'd0, out_valid}, 32'd0);
    chk("R8", "wb_valid idle", {31'd0, wb_valid}, 32'd0);
    chk("R8", "illegal idle", {31'd0, illegal}, 32'd0);

    // random mix with frequent aligned sums
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] b, i;
      logic [11:0] o;
      b = $urandom; i = $urandom; o = 12'($urandom);
      if (($urandom % 3) == 0) begin
        b[11:0] = 12'd0;
        i[9:0]  = 10'd0;
      end
      run_op(b, i, o, 2'($urandom), 1'($urandom), 1'($urandom), 5'($urandom), "R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule